// File: doc/BRIEF.md
# Multicycle Datapath ALU with Function-Class Select

This block is the arithmetic and logic unit for a datapath that finishes each instruction in several clock cycles. The unit has no state. It first forms two 32-bit operands. The first operand is the program counter or the x register. The second operand is the constant 4, the y register, the extended 16-bit immediate, or that immediate shifted left by two. It then forms a 32-bit result. A 2-bit class code picks one of four result paths: upper-immediate load, signed set-less-than, add/subtract and bitwise logic.

The zero flag and result bit 31 go to the control logic, which uses them for branch decisions. An overflow flag goes out on arithmetic operations so that control can raise an exception. The set-less-than path reuses the subtractor and corrects the sign of the difference for overflow. The control unit decodes instructions and drives the select inputs. The registers around the unit hold its operands and its result.

Top module: `mcalu_core`

## Requirements
- R1: The x select input picks the first operand: 0 = program counter, 1 = x register.
- R2: The 2-bit y select input picks the second operand: 0 = constant 4, 1 = y register, 2 = extended immediate, 3 = extended immediate shifted left by two.
- R3: The immediate is zero-extended when the class is 2'b11 (logic) and sign-extended for every other class.
- R4: With class 2'b10 (arithmetic), the result is X+Y modulo 2^32 when the subtract bit is 0, and X-Y modulo 2^32 when it is 1.
- R5: The overflow output is 1 only for class 2'b10, and only when the true signed sum or difference falls outside the signed 32-bit range. For every other class it is 0.
- R6: With class 2'b01 (set less than), result bit 0 is 1 exactly when X < Y as signed numbers, including when X-Y overflows. Bits 31..1 are 0. The subtract bit has no effect in this class.
- R7: With class 2'b11 (logic), the logic select picks the operation: 2'b00 = AND, 2'b01 = OR, 2'b10 = XOR, 2'b11 = NOR of X and Y.
- R8: With class 2'b00 (upper load), the result is the 16-bit immediate in bits 31..16 with zeros in bits 15..0. The operands and their selects have no effect.
- R9: The zero output is 1 exactly when all 32 result bits are 0. The sign output equals result bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Program counter value |
| xreg_i | input | 32 | x register value |
| yreg_i | input | 32 | y register value |
| imm_i | input | 16 | Instruction immediate |
| xsel_i | input | 1 | First operand select |
| ysel_i | input | 2 | Second operand select |
| fn_class_i | input | 2 | Result class select |
| logic_fn_i | input | 2 | Bitwise operation select |
| sub_i | input | 1 | Subtract when 1, add when 0 |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | Result is all zeros |
| sign_o | output | 1 | Result bit 31 |
| ovf_o | output | 1 | Signed overflow on arithmetic class |

## Verification
The assertions assume that every select input has a defined 0/1 value whenever the operands change. They also assume that the output paths settle before the values are read, so they are checked on fully settled combinational values. The stimulus keeps to this rule. Inputs change only just after a rising clock edge, and the outputs are compared at the following falling edge. Every code of the class, logic, x and y selects is valid, so random stimulus can sweep the full input space. Directed vectors add the signed range limits, results that are exactly zero, and set-less-than cases where the subtraction overflows.

// File: rtl/mcalu_pkg.sv
`timescale 1ns/1ps
package mcalu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 16;

  typedef enum logic [1:0] {
    CLS_UPPER = 2'b00,
    CLS_SLT   = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_LOGIC = 2'b11
  } alu_class_e;

  typedef enum logic [1:0] {
    LF_AND = 2'b00,
    LF_OR  = 2'b01,
    LF_XOR = 2'b10,
    LF_NOR = 2'b11
  } logic_fn_e;

  typedef enum logic [1:0] {
    YS_FOUR = 2'b00,
    YS_YREG = 2'b01,
    YS_IMM  = 2'b10,
    YS_IMM4 = 2'b11
  } ysel_e;
endpackage

// File: rtl/mcalu_opsel.sv
`timescale 1ns/1ps
module mcalu_opsel
  import mcalu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] xreg_i,
  input  logic [DW-1:0] yreg_i,
  input  logic [IW-1:0] imm_i,
  input  logic          xsel_i,
  input  logic [1:0]    ysel_i,
  input  logic          zext_i,
  output logic [DW-1:0] opx_o,
  output logic [DW-1:0] opy_o
);
  localparam int unsigned EXT_W = DW - IW;

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] imm_x4;

  always_comb begin
    if (zext_i) imm_ext = {{EXT_W{1'b0}}, imm_i};
    else        imm_ext = {{EXT_W{imm_i[IW-1]}}, imm_i};
    imm_x4 = {imm_ext[DW-3:0], 2'b00};
  end

  always_comb begin
    opx_o = xsel_i ? xreg_i : pc_i;
    unique case (ysel_e'(ysel_i))
      YS_FOUR: opy_o = DW'(4);
      YS_YREG: opy_o = yreg_i;
      YS_IMM:  opy_o = imm_ext;
      default: opy_o = imm_x4;
    endcase
  end

  // R3: a zero-extended immediate never has upper bits set
  always_comb begin
    if (zext_i && ysel_i == 2'b10)
      a_r3_zext_upper: assert (opy_o[DW-1:IW] == '0)
        else $error("a_r3_zext_upper");
  end
endmodule

// File: rtl/mcalu_addsub.sv
`timescale 1ns/1ps
module mcalu_addsub #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          ovf_o
);
  logic [DW-1:0] b_eff;
  logic [DW-1:0] low;
  logic [1:0]    high;
  logic          c_msb;

  always_comb begin
    b_eff = b_i ^ {DW{sub_i}};
    low   = {1'b0, a_i[DW-2:0]} + {1'b0, b_eff[DW-2:0]} + {{(DW-1){1'b0}}, sub_i};
    c_msb = low[DW-1];
    high  = {1'b0, a_i[DW-1]} + {1'b0, b_eff[DW-1]} + {1'b0, c_msb};
    sum_o = {high[0], low[DW-2:0]};
    ovf_o = high[1] ^ c_msb;
  end

  // R5: carry-based overflow agrees with the operand/result sign rule
  always_comb begin
    a_r5_ovf_sign_rule: assert (ovf_o ==
        ((a_i[DW-1] == b_eff[DW-1]) && (sum_o[DW-1] != a_i[DW-1])))
      else $error("a_r5_ovf_sign_rule");
  end
endmodule

// File: rtl/mcalu_logic.sv
`timescale 1ns/1ps
module mcalu_logic
  import mcalu_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    fn_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (logic_fn_e'(fn_i))
      LF_AND:  y_o = a_i & b_i;
      LF_OR:   y_o = a_i | b_i;
      LF_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

  // R7: AND never sets a bit absent from either input; NOR clears every bit set in an input
  always_comb begin
    if (fn_i == 2'b00)
      a_r7_and_subset: assert (((y_o & ~a_i) | (y_o & ~b_i)) == '0)
        else $error("a_r7_and_subset");
    if (fn_i == 2'b11)
      a_r7_nor_disjoint: assert (((y_o & a_i) | (y_o & b_i)) == '0)
        else $error("a_r7_nor_disjoint");
  end
endmodule

// File: rtl/mcalu_core.sv
`timescale 1ns/1ps
module mcalu_core
  import mcalu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] xreg_i,
  input  logic [DW-1:0] yreg_i,
  input  logic [IW-1:0] imm_i,
  input  logic          xsel_i,
  input  logic [1:0]    ysel_i,
  input  logic [1:0]    fn_class_i,
  input  logic [1:0]    logic_fn_i,
  input  logic          sub_i,
  output logic [DW-1:0] result_o,
  output logic          zero_o,
  output logic          sign_o,
  output logic          ovf_o
);
  localparam int unsigned LOW_W = DW - IW;

  alu_class_e    cls;
  logic          zext;
  logic          sub_eff;
  logic [DW-1:0] opx;
  logic [DW-1:0] opy;
  logic [DW-1:0] sum;
  logic          ovf_raw;
  logic [DW-1:0] lres;
  logic [DW-1:0] upper;
  logic [DW-1:0] slt_res;

  always_comb begin
    cls     = alu_class_e'(fn_class_i);
    zext    = (cls == CLS_LOGIC);
    sub_eff = sub_i | (cls == CLS_SLT);
  end

  mcalu_opsel #(.DW(DW), .IW(IW)) u_opsel (
    .pc_i   (pc_i),
    .xreg_i (xreg_i),
    .yreg_i (yreg_i),
    .imm_i  (imm_i),
    .xsel_i (xsel_i),
    .ysel_i (ysel_i),
    .zext_i (zext),
    .opx_o  (opx),
    .opy_o  (opy)
  );

  mcalu_addsub #(.DW(DW)) u_addsub (
    .a_i   (opx),
    .b_i   (opy),
    .sub_i (sub_eff),
    .sum_o (sum),
    .ovf_o (ovf_raw)
  );

  mcalu_logic #(.DW(DW)) u_logic (
    .a_i  (opx),
    .b_i  (opy),
    .fn_i (logic_fn_i),
    .y_o  (lres)
  );

  always_comb begin
    upper   = {imm_i, {LOW_W{1'b0}}};
    slt_res = {{(DW-1){1'b0}}, sum[DW-1] ^ ovf_raw};
    unique case (cls)
      CLS_UPPER: result_o = upper;
      CLS_SLT:   result_o = slt_res;
      CLS_ARITH: result_o = sum;
      default:   result_o = lres;
    endcase
    ovf_o  = ovf_raw & (cls == CLS_ARITH);
    zero_o = ~|result_o;
    sign_o = result_o[DW-1];
  end

  always_comb begin
    if (fn_class_i == 2'b00)
      a_r8_upper_low_clear: assert (result_o[LOW_W-1:0] == '0)
        else $error("a_r8_upper_low_clear");
    if (fn_class_i == 2'b01)
      a_r6_slt_single_bit: assert (result_o[DW-1:1] == '0)
        else $error("a_r6_slt_single_bit");
    if (fn_class_i != 2'b10)
      a_r5_no_overflow: assert (!ovf_o)
        else $error("a_r5_no_overflow");
  end
endmodule

// File: tb/sim_mcalu_core.sv
`timescale 1ns/1ps
module sim_mcalu_core;
  logic        clk;
  logic        rst_n;
  logic [31:0] pc, xr, yr;
  logic [15:0] imm;
  logic        xsel, sub;
  logic [1:0]  ysel, cls, lfn;
  logic [31:0] result;
  logic        zero, sign, ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  mcalu_core u0 (
    .pc_i(pc), .xreg_i(xr), .yreg_i(yr), .imm_i(imm),
    .xsel_i(xsel), .ysel_i(ysel), .fn_class_i(cls),
    .logic_fn_i(lfn), .sub_i(sub),
    .result_o(result), .zero_o(zero), .sign_o(sign), .ovf_o(ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input string rtag,
                       input logic [31:0] p, input logic [31:0] x,
                       input logic [31:0] y, input logic [15:0] im,
                       input logic xs, input logic [1:0] ys,
                       input logic [1:0] c, input logic [1:0] lf,
                       input logic sb);
    longint opx, opy, sx, sy, s, immv;
    logic [31:0] exp_r;
    logic        exp_o;
    string       tag;
    @(posedge clk);
    #1;
    pc = p; xr = x; yr = y; imm = im; xsel = xs; ysel = ys;
    cls = c; lfn = lf; sub = sb;
    opx  = xs ? longint'(x) : longint'(p);
    immv = (c == 2'd3) ? longint'(im) : longint'($signed(im));
    case (ys)
      2'd0: opy = 4;
      2'd1: opy = longint'(y);
      2'd2: opy = immv;
      default: opy = immv * 4;
    endcase
    opx = opx & 64'hFFFF_FFFF;
    opy = opy & 64'hFFFF_FFFF;
    sx = (opx >= 64'h8000_0000) ? opx - 64'h1_0000_0000 : opx;
    sy = (opy >= 64'h8000_0000) ? opy - 64'h1_0000_0000 : opy;
    exp_o = 1'b0;
    case (c)
      2'd0: begin exp_r = {im, 16'h0}; tag = "R8"; end
      2'd1: begin exp_r = (sx < sy) ? 32'd1 : 32'd0; tag = "R6"; end
      2'd2: begin
        s = sb ? sx - sy : sx + sy;
        exp_r = s[31:0];
        exp_o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        tag = "R4";
      end
      default: begin
        case (lf)
          2'd0: exp_r = opx[31:0] & opy[31:0];
          2'd1: exp_r = opx[31:0] | opy[31:0];
          2'd2: exp_r = opx[31:0] ^ opy[31:0];
          default: exp_r = ~(opx[31:0] | opy[31:0]);
        endcase
        tag = "R7";
      end
    endcase
    if (rtag != "") tag = rtag;
    @(negedge clk);
    chk({tag, " result"}, longint'(result), longint'(exp_r));
    chk("R5 overflow", longint'(ovf), longint'(exp_o));
    chk("R9 zero", longint'(zero), longint'(exp_r == 32'd0));
    chk("R9 sign", longint'(sign), longint'(exp_r[31]));
  endtask

  initial begin
    rst_n = 1'b0;
    pc = '0; xr = '0; yr = '0; imm = '0; xsel = 0; ysel = 0;
    cls = 0; lfn = 0; sub = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // initial state: upper load of zero gives zero flag
    chk("R9 reset zero", longint'(zero), 1);
    chk("R8 reset result", longint'(result), 0);
    // R1: first operand select
    apply("R1", 32'h0000_1000, 32'h0000_0200, 0, 0, 0, 2'd0, 2'd2, 0, 0);
    apply("R1", 32'h0000_1000, 32'h0000_0200, 0, 0, 1, 2'd0, 2'd2, 0, 0);
    // R2: all second-operand codes
    apply("R2", 0, 32'd10, 32'd77, 16'h0005, 1, 2'd0, 2'd2, 0, 0);
    apply("R2", 0, 32'd10, 32'd77, 16'h0005, 1, 2'd1, 2'd2, 0, 0);
    apply("R2", 0, 32'd10, 32'd77, 16'h0005, 1, 2'd2, 2'd2, 0, 0);
    apply("R2", 0, 32'd10, 32'd77, 16'hFFFF, 1, 2'd3, 2'd2, 0, 0);
    // R3: sign versus zero extension of a negative immediate
    apply("R3", 0, 32'd0, 0, 16'h8001, 1, 2'd2, 2'd2, 0, 0);
    apply("R3", 0, 32'd0, 0, 16'h8001, 1, 2'd2, 2'd3, 2'd1, 0);
    // R4 / R5 overflow edges
    apply("R5", 0, 32'h7FFF_FFFF, 32'd1, 0, 1, 2'd1, 2'd2, 0, 0);
    apply("R5", 0, 32'h8000_0000, 32'd1, 0, 1, 2'd1, 2'd2, 0, 1);
    apply("R4", 0, 32'h1234_5678, 32'h1234_5678, 0, 1, 2'd1, 2'd2, 0, 1);
    apply("R5", 0, 32'h8000_0000, 32'h8000_0000, 0, 1, 2'd1, 2'd2, 0, 0);
    // R6: overflowing compare, subtract bit ignored, equal operands
    apply("R6", 0, 32'h8000_0000, 32'd1, 0, 1, 2'd1, 2'd1, 0, 0);
    apply("R6", 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 1, 2'd1, 2'd1, 0, 1);
    apply("R6", 0, 32'd5, 32'd5, 0, 1, 2'd1, 2'd1, 0, 0);
    // R7: each logic code
    for (int f = 0; f < 4; f++)
      apply("R7", 0, 32'hF0F0_1234, 32'h0FF0_5678, 0, 1, 2'd1, 2'd3, f[1:0], 0);
    // R8: operands ignored
    apply("R8", 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h1, 16'hABCD, 1, 2'd3, 2'd0, 2'd3, 1);
    apply("R8", 0, 0, 0, 16'h8000, 0, 2'd0, 2'd0, 0, 0);
    // random sweep
    for (int i = 0; i < 3000; i++)
      apply("", $urandom, (i % 7 == 0) ? 32'h8000_0000 : $urandom,
            (i % 5 == 0) ? 32'h7FFF_FFFF : $urandom, 16'($urandom),
            1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule